// File: doc/BRIEF.md
# Six-Source Interrupt Enable and Poll Unit

This block gathers six interrupt sources for a small CPU core: two external request levels, the overflow flags of three timers and a serial port request level. It holds an 8-bit enable register. Six bits gate one source each and one bit gates all sources at once. Once per machine cycle a poll strobe samples the gated sources. The block then presents the most urgent pending source to the CPU as a request, a source index and a 16-bit vector address. These outputs stay fixed until the next poll or until the CPU acknowledges.

The block stores the timer flags itself. Timer 0 and timer 1 flags are set by overflow pulses and cleared by the acknowledge of their own request. A set pulse that arrives in the same clock as a poll is only seen by the following poll. Timer 2 has two flags, an overflow flag and an external-event flag, and raises one request from their OR. Its set pulses are seen by the poll in the same clock. Its flags are never cleared by the acknowledge and are cleared only by explicit software clear strobes. The serial request level belongs to the serial port, and the block never clears it.

Top module: `irq_enable_unit`

## Requirements
- R1: After reset the enable register reads 0x00, `irq` is 0, `irq_src` is 0, `irq_vec` is 0x0000 and `tmr_flags` is 0. A poll with every source active then raises no request.
- R2: Enable register layout: bits 0..5 enable the sources by index (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2), and bit 7 is the global enable. Bit 6 is unimplemented: it always reads 0, and writing 1 to it has no effect.
- R3: While the global enable bit is 0, a poll produces `irq` = 0 whatever the sources and per-source bits are.
- R4: When several enabled sources are pending at a poll, the lowest index wins. `irq_src` carries that index and `irq_vec` = 0x0003 + 8 × index. With no pending source, `irq`, `irq_src` and `irq_vec` are all 0.
- R5: The outputs load only in a clock in which `poll` is 1, and otherwise hold until an acknowledge. A poll uses the enable value from before an enable write in the same clock.
- R6: A timer 0 or timer 1 overflow pulse in the same clock as a poll is not seen by that poll. The flag is set and the next poll sees it.
- R7: The timer 2 request is the OR of its overflow flag and its external flag. A set pulse of either flag in the same clock as a poll is seen by that poll.
- R8: Acknowledging a timer 2 request leaves both timer 2 flags set. `tmr2_clr[0]` clears the overflow flag and `tmr2_clr[1]` clears the external flag.
- R9: `ack` while `irq` is 1 drops `irq` on the next clock. If the acknowledged source is timer 0 or timer 1, `ack` also clears that flag. When a poll falls in the same clock as the acknowledge, the poll excludes the flag being cleared and loads the next winner.
- R10: When a flag's set pulse and its clear fall in the same clock, the flag ends up set.
- R11: `tmr_flags` shows the stored flags: bit 0 timer 0 overflow, bit 1 timer 1 overflow, bit 2 timer 2 overflow, bit 3 timer 2 external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | One-clock strobe per machine cycle that samples the sources |
| ack | input | 1 | CPU acknowledge of the presented request |
| ext0_lvl | input | 1 | External request 0 level |
| ext1_lvl | input | 1 | External request 1 level |
| ser_lvl | input | 1 | Serial port request level |
| tmr0_ovf | input | 1 | Timer 0 overflow set pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow set pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow set pulse |
| tmr2_ext | input | 1 | Timer 2 external-event set pulse |
| tmr2_clr | input | 2 | Software clear strobes for the timer 2 flags (bit 0 overflow, bit 1 external) |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read-back |
| irq | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_src | output | 3 | Index of the presented source |
| tmr_flags | output | 4 | Stored timer flags |

## Verification
Two pairs of functions can fall in one clock, and the bench drives each pair on purpose in a single cycle. The first pair is an acknowledge of a timer 0 request and a new poll. With timer 0 and timer 1 both flagged, the bench must then see timer 1 presented and only the timer 0 flag gone. The second pair is an acknowledge that clears a timer 0 flag and a new overflow pulse on that same flag; the bench judges it by the flag read-back, which must stay 1. The bench also pairs a poll with a set pulse, where timer 0 must miss the poll and timer 2 must catch it. It pairs a poll with an enable write as well, where the old enable value must decide.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

  localparam int unsigned NSRC      = 6;
  localparam int unsigned SRC_W     = 3;
  localparam int unsigned EN_W      = 8;
  localparam int unsigned GLB_BIT   = 7;
  localparam int unsigned VEC_W     = 16;
  localparam int unsigned VEC_SHIFT = 3;
  localparam int unsigned NFLAG     = 4;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  // flag slots inside the flag store
  localparam int unsigned FL_T0  = 0;
  localparam int unsigned FL_T1  = 1;
  localparam int unsigned FL_T2O = 2;
  localparam int unsigned FL_T2E = 3;

  // vector address: fixed base plus a stride of eight per source index
  function automatic logic [VEC_W-1:0] vector_of(input logic [SRC_W-1:0] idx);
    return VEC_BASE + (VEC_W'(idx) << VEC_SHIFT);
  endfunction

  // bits of the enable register that hold storage
  function automatic logic [EN_W-1:0] impl_mask();
    logic [EN_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NSRC); i++) m[i] = 1'b1;
    m[GLB_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_en_pkg::*;
#(
  parameter int unsigned W = EN_W,
  parameter int unsigned N = NSRC,
  parameter int unsigned G = GLB_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [N-1:0] src_en,
  output logic         glb_en
);

  localparam logic [W-1:0] IMPL = W'(impl_mask());

  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata & IMPL;
  end

  assign rdata  = en_q;
  assign src_en = en_q[N-1:0];
  assign glb_en = en_q[G];

  // R2: the read-back after a write keeps only implemented bits
  assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == ($past(wdata) & IMPL)));

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q,
  output logic [N-1:0] nxt
);

  logic [N-1:0] q_r;

  for (genvar i = 0; i < int'(N); i++) begin : g_flag
    // set outranks clear so a fresh event is never lost
    assign nxt[i] = set[i] | (q_r[i] & ~clr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= nxt[i];
    end

    // R10: a set pulse always leaves the flag set
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q_r[i]);

    // R9: a clear without a competing set empties the flag
    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q_r[i]);
  end

  assign q = q_r;

endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_en_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned SW = SRC_W,
  parameter int unsigned VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic          ack,
  input  logic [N-1:0]  pend,
  output logic          irq,
  output logic [SW-1:0] src,
  output logic [VW-1:0] vec
);

  logic          any_pend;
  logic [SW-1:0] win_idx;
  logic [VW-1:0] win_vec;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    win_idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pend[i]) win_idx = SW'(i);
    end
  end

  assign any_pend = |pend;
  assign win_vec  = VW'(vector_of(SRC_W'(win_idx)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      src <= '0;
      vec <= '0;
    end else if (poll) begin
      irq <= any_pend;
      src <= any_pend ? win_idx : '0;
      vec <= any_pend ? win_vec : '0;
    end else if (ack) begin
      irq <= 1'b0;
      src <= '0;
      vec <= '0;
    end
  end

  // R5: outside poll and acknowledge nothing moves
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll && !ack) |=> ($stable(irq) && $stable(src) && $stable(vec)));

  // R4: the first source always wins when pending
  assert_first_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && pend[0]) |=> (irq && src == '0));

  // R9: an acknowledge without a poll drops the request
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !poll) |=> !irq);

endmodule

// File: rtl/irq_enable_unit.sv
module irq_enable_unit
  import irq_en_pkg::*;
#(
  parameter int unsigned P_NSRC  = NSRC,
  parameter int unsigned P_SRC_W = SRC_W,
  parameter int unsigned P_EN_W  = EN_W,
  parameter int unsigned P_VEC_W = VEC_W,
  parameter int unsigned P_NFLAG = NFLAG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll,
  input  logic               ack,
  input  logic               ext0_lvl,
  input  logic               ext1_lvl,
  input  logic               ser_lvl,
  input  logic               tmr0_ovf,
  input  logic               tmr1_ovf,
  input  logic               tmr2_ovf,
  input  logic               tmr2_ext,
  input  logic [1:0]         tmr2_clr,
  input  logic               en_we,
  input  logic [P_EN_W-1:0]  en_wdata,
  output logic [P_EN_W-1:0]  en_rdata,
  output logic               irq,
  output logic [P_VEC_W-1:0] irq_vec,
  output logic [P_SRC_W-1:0] irq_src,
  output logic [P_NFLAG-1:0] tmr_flags
);

  // named internal events
  logic               glb_en;
  logic [P_NSRC-1:0]  src_en;
  logic               ack_take;
  logic               hw_clr_t0;
  logic               hw_clr_t1;
  logic [P_NFLAG-1:0] flag_set;
  logic [P_NFLAG-1:0] flag_clr;
  logic [P_NFLAG-1:0] flag_q;
  logic [P_NFLAG-1:0] flag_nxt;
  logic               t0_vis;
  logic               t1_vis;
  logic               t2_vis;
  logic [P_NSRC-1:0]  raw_req;
  logic [P_NSRC-1:0]  pend;

  irq_en_reg #(.W(P_EN_W), .N(P_NSRC), .G(GLB_BIT)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (en_we),
    .wdata  (en_wdata),
    .rdata  (en_rdata),
    .src_en (src_en),
    .glb_en (glb_en)
  );

  // acknowledge only counts while a request is shown
  assign ack_take  = ack & irq;
  assign hw_clr_t0 = ack_take & (irq_src == P_SRC_W'(SRC_TMR0));
  assign hw_clr_t1 = ack_take & (irq_src == P_SRC_W'(SRC_TMR1));

  always_comb begin
    flag_set         = '0;
    flag_clr         = '0;
    flag_set[FL_T0]  = tmr0_ovf;
    flag_set[FL_T1]  = tmr1_ovf;
    flag_set[FL_T2O] = tmr2_ovf;
    flag_set[FL_T2E] = tmr2_ext;
    flag_clr[FL_T0]  = hw_clr_t0;
    flag_clr[FL_T1]  = hw_clr_t1;
    flag_clr[FL_T2O] = tmr2_clr[0];
    flag_clr[FL_T2E] = tmr2_clr[1];
  end

  irq_flags #(.N(P_NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q),
    .nxt   (flag_nxt)
  );

  // timer 0/1: only the stored flag counts, minus one being acknowledged now
  assign t0_vis = flag_q[FL_T0] & ~hw_clr_t0;
  assign t1_vis = flag_q[FL_T1] & ~hw_clr_t1;
  // timer 2: the flag value after this clock counts, so a same-cycle set is seen
  assign t2_vis = flag_nxt[FL_T2O] | flag_nxt[FL_T2E];

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_EXT0] = ext0_lvl;
    raw_req[SRC_TMR0] = t0_vis;
    raw_req[SRC_EXT1] = ext1_lvl;
    raw_req[SRC_TMR1] = t1_vis;
    raw_req[SRC_SER]  = ser_lvl;
    raw_req[SRC_TMR2] = t2_vis;
  end

  assign pend = raw_req & src_en & {P_NSRC{glb_en}};

  irq_poll #(.N(P_NSRC), .SW(P_SRC_W), .VW(P_VEC_W)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .poll  (poll),
    .ack   (ack),
    .pend  (pend),
    .irq   (irq),
    .src   (irq_src),
    .vec   (irq_vec)
  );

  assign tmr_flags = flag_q;

  // R3: global enable off means a poll yields no request
  assert_global_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !glb_en) |=> !irq);

  // R6: a timer 0 flag not yet stored cannot be presented by this poll
  assert_t0_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !flag_q[FL_T0]) |=> !(irq && irq_src == P_SRC_W'(SRC_TMR0)));

  // R7: a timer 2 set pulse with nothing ahead of it wins this poll
  assert_t2_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && tmr2_ovf && glb_en && src_en[SRC_TMR2] && (pend[SRC_SER:0] == '0))
      |=> (irq && irq_src == P_SRC_W'(SRC_TMR2)));

  // R8: the timer 2 overflow flag survives anything but its own clear
  assert_t2_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[FL_T2O] && !tmr2_clr[0]) |=> flag_q[FL_T2O]);

endmodule

// File: tb/irq_enable_unit_test.sv
`timescale 1ns/1ps
module irq_enable_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll = 1'b0, ack = 1'b0;
  logic        ext0_lvl = 1'b0, ext1_lvl = 1'b0, ser_lvl = 1'b0;
  logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_ovf = 1'b0, tmr2_ext = 1'b0;
  logic [1:0]  tmr2_clr = 2'b00;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = 8'h00;
  logic [7:0]  en_rdata;
  logic        irq;
  logic [15:0] irq_vec;
  logic [2:0]  irq_src;
  logic [3:0]  tmr_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_enable_unit uut (
    .clk(clk), .rst_n(rst_n), .poll(poll), .ack(ack),
    .ext0_lvl(ext0_lvl), .ext1_lvl(ext1_lvl), .ser_lvl(ser_lvl),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
    .tmr2_clr(tmr2_clr), .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .irq(irq), .irq_vec(irq_vec), .irq_src(irq_src), .tmr_flags(tmr_flags)
  );

  // table layout: [14:7] enable, [6] ext0, [5] ext1, [4] serial, [3] expect irq, [2:0] expect index
  localparam int NTBL = 10;
  localparam logic [14:0] TBL [NTBL] = '{
    {8'h85, 3'b111, 1'b1, 3'd0},
    {8'h84, 3'b111, 1'b1, 3'd2},
    {8'h90, 3'b111, 1'b1, 3'd4},
    {8'h95, 3'b001, 1'b1, 3'd4},
    {8'h95, 3'b011, 1'b1, 3'd2},
    {8'h9F, 3'b111, 1'b1, 3'd0},
    {8'h15, 3'b111, 1'b0, 3'd0},
    {8'hC0, 3'b111, 1'b0, 3'd0},
    {8'h80, 3'b111, 1'b0, 3'd0},
    {8'h81, 3'b011, 1'b0, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected vector computed from the index independently of the design
  function automatic logic [15:0] exp_vec(input logic on, input logic [2:0] idx);
    return on ? (16'd3 + 16'd8 * {13'd0, idx}) : 16'd0;
  endfunction

  task automatic check_out(input string tag, input logic on, input logic [2:0] idx);
    check({tag, " irq"}, 32'(irq), 32'(on));
    check({tag, " src"}, 32'(irq_src), on ? 32'(idx) : 32'd0);
    check({tag, " vec"}, 32'(irq_vec), 32'(exp_vec(on, idx)));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_poll();
    poll = 1'b1; tick(); poll = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic write_en(input logic [7:0] v);
    en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 en_rdata", 32'(en_rdata), 32'h00);
    check("R1 flags", 32'(tmr_flags), 32'h0);
    check_out("R1 idle", 1'b0, 3'd0);
    ext0_lvl = 1'b1; ext1_lvl = 1'b1; ser_lvl = 1'b1;
    do_poll();
    check_out("R1 disabled poll", 1'b0, 3'd0);
    ext0_lvl = 1'b0; ext1_lvl = 1'b0; ser_lvl = 1'b0;

    // R2 unimplemented bit
    write_en(8'hFF);
    check("R2 write FF", 32'(en_rdata), 32'hBF);
    write_en(8'h40);
    check("R2 write 40", 32'(en_rdata), 32'h00);

    // R4 / R3 table of level sources
    for (int i = 0; i < NTBL; i++) begin
      write_en(TBL[i][14:7]);
      ext0_lvl = TBL[i][6]; ext1_lvl = TBL[i][5]; ser_lvl = TBL[i][4];
      do_poll();
      check_out($sformatf("R4/R3 row %0d", i), TBL[i][3], TBL[i][2:0]);
    end
    ext0_lvl = 1'b0; ext1_lvl = 1'b0; ser_lvl = 1'b0;

    // R5 hold between polls
    write_en(8'h81);
    ext0_lvl = 1'b1;
    do_poll();
    check_out("R5 loaded", 1'b1, 3'd0);
    ext0_lvl = 1'b0;
    tick(); tick();
    check_out("R5 held", 1'b1, 3'd0);
    do_poll();
    check_out("R5 repoll", 1'b0, 3'd0);

    // R5 poll uses enable value before a same-cycle write
    write_en(8'h80);
    ext0_lvl = 1'b1;
    en_we = 1'b1; en_wdata = 8'h81; poll = 1'b1;
    tick();
    en_we = 1'b0; poll = 1'b0;
    check_out("R5 old enable", 1'b0, 3'd0);
    do_poll();
    check_out("R5 new enable", 1'b1, 3'd0);
    ext0_lvl = 1'b0;
    do_poll();

    // R6 timer 0 set during a poll is seen one poll later
    write_en(8'h82);
    tmr0_ovf = 1'b1; poll = 1'b1;
    tick();
    tmr0_ovf = 1'b0; poll = 1'b0;
    check_out("R6 same poll", 1'b0, 3'd0);
    check("R11 t0 flag", 32'(tmr_flags), 32'h1);
    do_poll();
    check_out("R6 next poll", 1'b1, 3'd1);

    // R9 acknowledge clears timer 0
    do_ack();
    check("R9 t0 cleared", 32'(tmr_flags), 32'h0);
    check_out("R9 dropped", 1'b0, 3'd0);

    // R9 acknowledge and poll in the same cycle
    write_en(8'h8A);
    tmr0_ovf = 1'b1; tmr1_ovf = 1'b1;
    tick();
    tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    do_poll();
    check_out("R9 t0 first", 1'b1, 3'd1);
    ack = 1'b1; poll = 1'b1;
    tick();
    ack = 1'b0; poll = 1'b0;
    check_out("R9 ack+poll next", 1'b1, 3'd3);
    check("R9 ack+poll flags", 32'(tmr_flags), 32'h2);
    do_ack();
    check("R9 t1 cleared", 32'(tmr_flags), 32'h0);

    // R10 set and clear in the same cycle
    write_en(8'h82);
    tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
    do_poll();
    ack = 1'b1; tmr0_ovf = 1'b1;
    tick();
    ack = 1'b0; tmr0_ovf = 1'b0;
    check("R10 set wins", 32'(tmr_flags), 32'h1);
    check_out("R10 irq dropped", 1'b0, 3'd0);
    do_poll();
    do_ack();

    // R7 timer 2 overflow visible in the same poll
    write_en(8'hA0);
    tmr2_ovf = 1'b1; poll = 1'b1;
    tick();
    tmr2_ovf = 1'b0; poll = 1'b0;
    check_out("R7 same poll", 1'b1, 3'd5);

    // R8 acknowledge leaves timer 2 flags, software clear removes them
    do_ack();
    check("R8 flag kept", 32'(tmr_flags), 32'h4);
    check_out("R8 ack drop", 1'b0, 3'd0);
    do_poll();
    check_out("R8 re-presented", 1'b1, 3'd5);
    tmr2_clr = 2'b01; tick(); tmr2_clr = 2'b00;
    check("R8 sw clear ovf", 32'(tmr_flags), 32'h0);
    do_poll();
    check_out("R8 gone", 1'b0, 3'd0);

    // R7 external flag alone raises timer 2
    tmr2_ext = 1'b1; tick(); tmr2_ext = 1'b0;
    check("R11 t2 ext flag", 32'(tmr_flags), 32'h8);
    do_poll();
    check_out("R7 ext flag", 1'b1, 3'd5);
    tmr2_clr = 2'b10; tick(); tmr2_clr = 2'b00;
    do_poll();
    check_out("R8 ext cleared", 1'b0, 3'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule